// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block decides which of eight analog channels is converted next and when. The host supplies a channel-enable mask, a starting channel, a sequencing mode, a result width, a reference-select bit and an interrupt enable. A start write loads the channel pointer and begins converting. The pointer moves upward through the enabled channels, skips the disabled ones, and wraps from channel 7 to channel 0. The same pointer drives the input multiplexer select and the result slot.

Each conversion is handed to an external successive-approximation engine. The block raises a one-cycle start pulse with the channel and width. The engine answers with a one-cycle done pulse and a result; it takes 14 cycles for a 10-bit result and 12 for an 8-bit result. The block then writes the result into the register pair for that channel and sets a completion flag. It can also pull an active-low interrupt line. There are three modes: one conversion per host step command, one automatic pass over the enabled channels, or repeated passes.

Top module: `conv_sequencer`

## Requirements
- R1: When `ref_ext` is 1, channel 0 is excluded from conversion whatever bit 0 of `ch_mask` holds; `ch_mask` bit n enables channel n.
- R2: A start write converts first the lowest-offset enabled channel at or above `start_ch`, counting upward modulo 8. Later conversions follow in ascending order, wrapping from 7 to 0 and skipping disabled channels.
- R3: With `mode` = 2'b01 (single pass), each enabled channel is converted exactly once. The pass ends before the pointer would return to the starting channel, and busy then clears.
- R4: With `mode` = 2'b10 or 2'b11 (continuous), passes repeat without end. If the mode changes to single pass, the current pass completes and the block goes idle.
- R5: With `mode` = 2'b00 (step), each start write or `step_cmd` pulse converts exactly one channel. Each `step_cmd` moves to the next enabled channel, wrapping past the last one.
- R6: A start write whose effective mask (after R1) is empty is ignored: no conversion is launched and busy never sets.
- R7: A start write while a conversion is being launched or is in flight is ignored, and the running sequence continues unchanged.
- R8: The result is written on `res_wr` to slot `res_ch`. In 10-bit mode, `res_hi` = {6'b0, result[9:8]} and `res_lo` = result[7:0]. In 8-bit mode, `res_hi` = 0 and `res_lo` = result[9:2]. The width is the one given to the engine at launch.
- R9: `status[0]` is busy, meaning a conversion is being launched or awaited. `status[1]` is complete: it sets on every result write and clears on a `stat_rd` pulse.
- R10: `irq_n` is 0 exactly when complete is set and `irq_en` is 1; otherwise it is 1.
- R11: `conv_start` is a single-cycle pulse. At most one conversion is outstanding, and `conv_done` is accepted only while one is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 step, 01 single pass, 1x continuous |
| ref_ext | input | 1 | Channel 0 used as external reference |
| wide | input | 1 | 1 = 10-bit conversions, 0 = 8-bit |
| irq_en | input | 1 | Interrupt enable |
| ch_mask | input | 8 | Channel enable mask |
| start_wr | input | 1 | Start-channel write strobe |
| start_ch | input | 3 | Starting channel |
| step_cmd | input | 1 | Step command (step mode) |
| stat_rd | input | 1 | Status read strobe |
| conv_start | output | 1 | Launch pulse to the engine |
| conv_ch | output | 3 | Channel address (mux select) |
| conv_wide | output | 1 | Width requested from the engine |
| conv_done | input | 1 | Engine completion pulse |
| conv_result | input | 10 | Engine result, left-justified |
| res_wr | output | 1 | Result register write strobe |
| res_ch | output | 3 | Result register slot |
| res_hi | output | 8 | Upper result register value |
| res_lo | output | 8 | Lower result register value |
| status | output | 2 | {complete, busy} |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Several properties are checked on every cycle by the assertions. The launch pulse lasts one cycle. A result is written only while busy. The interrupt never asserts without the complete flag. A status read clears the flag. A start with an empty mask never raises busy. The scenarios are the only way to show the order in which channels are visited: the starting point, skipping, wrap-around, where a pass ends, continuous repetition and its stop on a mode change, and one conversion per step command. They also show the result layout in both widths and that channel 0 is excluded in external-reference mode.

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int NCH = 8,
  parameter int RW  = 10,
  parameter int BW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode,
  input  logic                   ref_ext,
  input  logic                   wide,
  input  logic                   irq_en,
  input  logic [NCH-1:0]         ch_mask,
  input  logic                   start_wr,
  input  logic [$clog2(NCH)-1:0] start_ch,
  input  logic                   step_cmd,
  input  logic                   stat_rd,
  output logic                   conv_start,
  output logic [$clog2(NCH)-1:0] conv_ch,
  output logic                   conv_wide,
  input  logic                   conv_done,
  input  logic [RW-1:0]          conv_result,
  output logic                   res_wr,
  output logic [$clog2(NCH)-1:0] res_ch,
  output logic [BW-1:0]          res_hi,
  output logic [BW-1:0]          res_lo,
  output logic [1:0]             status,
  output logic                   irq_n
);
  localparam int CW = $clog2(NCH);

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_HOLD} state_t;

  state_t          state;
  logic [CW-1:0]   base_q, ofs_q;
  logic            wide_q, done_q;
  logic [NCH-1:0]  eff;
  logic [CW:0]     first, after, again;
  logic            busy, go, step_mode, cont_mode;

  function automatic logic [CW:0] seek(input logic [NCH-1:0] m,
                                       input logic [CW-1:0] base,
                                       input logic [CW:0] lo);
    logic [CW-1:0] idx;
    seek = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      idx = base + CW'(i);
      if (i >= int'(lo) && m[idx]) seek = {1'b1, CW'(i)};
    end
  endfunction

  assign eff       = ch_mask & ~{{(NCH-1){1'b0}}, ref_ext};
  assign first     = seek(eff, start_ch, '0);
  assign after     = seek(eff, base_q, {1'b0, ofs_q} + 1'b1);
  assign again     = seek(eff, base_q, '0);
  assign busy      = (state == S_LAUNCH) || (state == S_WAIT);
  assign go        = start_wr && first[CW] && !busy;
  assign step_mode = (mode == 2'b00);
  assign cont_mode = mode[1];

  assign conv_start = (state == S_LAUNCH);
  assign conv_ch    = base_q + ofs_q;
  assign conv_wide  = wide_q;
  assign res_wr     = (state == S_WAIT) && conv_done;
  assign res_ch     = conv_ch;
  assign res_hi     = wide_q ? BW'(conv_result[RW-1:BW]) : '0;
  assign res_lo     = wide_q ? conv_result[BW-1:0] : conv_result[RW-1:RW-BW];
  assign status     = {done_q, busy};
  assign irq_n      = !(done_q && irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      base_q <= '0;
      ofs_q  <= '0;
      wide_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (res_wr)       done_q <= 1'b1;
      else if (stat_rd) done_q <= 1'b0;

      if (go) begin
        base_q <= start_ch;
        ofs_q  <= first[CW-1:0];
        wide_q <= wide;
        state  <= S_LAUNCH;
      end else begin
        case (state)
          S_LAUNCH: state <= S_WAIT;
          S_WAIT: if (conv_done) begin
            if (step_mode) state <= S_HOLD;
            else if (after[CW]) begin
              ofs_q  <= after[CW-1:0];
              wide_q <= wide;
              state  <= S_LAUNCH;
            end else if (cont_mode && again[CW]) begin
              ofs_q  <= again[CW-1:0];
              wide_q <= wide;
              state  <= S_LAUNCH;
            end else state <= S_IDLE;
          end
          S_HOLD: if (step_cmd) begin
            if (after[CW]) begin
              ofs_q  <= after[CW-1:0];
              wide_q <= wide;
              state  <= S_LAUNCH;
            end else if (again[CW]) begin
              ofs_q  <= again[CW-1:0];
              wide_q <= wide;
              state  <= S_LAUNCH;
            end else state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_write_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> status[0]);

  assert_write_sets_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> status[1]);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !res_wr) |=> !status[1]);

  assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> status[1]);

  assert_empty_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && eff == '0 && !status[0]) |=> !status[0]);

  assert_ref_excludes_ch0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && ref_ext && $stable(ref_ext)) |-> conv_ch != '0);
endmodule

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode = 2'b01;
  logic ref_ext = 0, wide = 1, irq_en = 1;
  logic [7:0] ch_mask = 0;
  logic start_wr = 0, step_cmd = 0, stat_rd = 0;
  logic [2:0] start_ch = 0;
  logic conv_start, conv_wide, res_wr, irq_n;
  logic [2:0] conv_ch, res_ch;
  logic conv_done = 0;
  logic [9:0] conv_result = 0;
  logic [7:0] res_hi, res_lo;
  logic [1:0] status;

  int tests = 0, fails = 0;
  int log_ch[64], log_hi[64], log_lo[64];
  int log_n = 0, cs_cnt = 0;
  int e_cnt = 0;
  logic [2:0] e_ch = 0;

  always #2 clk = ~clk;

  conv_sequencer i_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ref_ext(ref_ext), .wide(wide),
    .irq_en(irq_en), .ch_mask(ch_mask), .start_wr(start_wr), .start_ch(start_ch),
    .step_cmd(step_cmd), .stat_rd(stat_rd), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_wide(conv_wide), .conv_done(conv_done),
    .conv_result(conv_result), .res_wr(res_wr), .res_ch(res_ch),
    .res_hi(res_hi), .res_lo(res_lo), .status(status), .irq_n(irq_n));

  function automatic int rval(input int ch);
    return ch * 100 + 37;
  endfunction

  always @(posedge clk) begin
    #1;
    conv_done = 0;
    if (e_cnt > 0) begin
      e_cnt--;
      if (e_cnt == 0) begin
        conv_done = 1;
        conv_result = 10'(rval(int'(e_ch)));
      end
    end
    if (conv_start) begin
      e_ch = conv_ch;
      e_cnt = conv_wide ? 14 : 12;
    end
  end

  always @(negedge clk) begin
    if (res_wr && log_n < 64) begin
      log_ch[log_n] = int'(res_ch);
      log_hi[log_n] = int'(res_hi);
      log_lo[log_n] = int'(res_lo);
      log_n++;
    end
    if (conv_start) cs_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [2:0] ch);
    @(negedge clk); start_wr = 1; start_ch = ch;
    @(negedge clk); start_wr = 0;
  endtask

  task automatic do_step();
    @(negedge clk); step_cmd = 1;
    @(negedge clk); step_cmd = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!status[0]) break;
    end
  endtask

  task automatic t_reset();
    chk(status == 2'b00, "R9 reset status", int'(status), 0);
    chk(irq_n == 1'b1, "R10 reset irq_n", int'(irq_n), 1);
    chk(conv_start == 1'b0, "R11 reset conv_start", int'(conv_start), 0);
  endtask

  task automatic t_single_pass();
    int exp_ch[5] = '{5, 7, 1, 2, 4};
    int b;
    mode = 2'b01; wide = 1; ref_ext = 0; irq_en = 1; ch_mask = 8'b1011_0110;
    b = log_n;
    do_start(3'd5);
    repeat (4) @(negedge clk);
    @(negedge clk); start_wr = 1; start_ch = 3'd0;
    @(negedge clk); start_wr = 0;
    wait_idle();
    chk(log_n - b == 5, "R3 pass length", log_n - b, 5);
    for (int k = 0; k < 5; k++) begin
      chk(log_ch[b+k] == exp_ch[k], "R2 R7 channel order", log_ch[b+k], exp_ch[k]);
      chk(log_hi[b+k] == (rval(exp_ch[k]) >> 8), "R8 wide hi", log_hi[b+k], rval(exp_ch[k]) >> 8);
      chk(log_lo[b+k] == (rval(exp_ch[k]) & 255), "R8 wide lo", log_lo[b+k], rval(exp_ch[k]) & 255);
    end
    chk(status == 2'b10, "R3 R9 idle and complete", int'(status), 2);
    chk(irq_n == 1'b0, "R10 irq asserted", int'(irq_n), 0);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk(status == 2'b00, "R9 read clears", int'(status), 0);
    chk(irq_n == 1'b1, "R10 irq released", int'(irq_n), 1);
  endtask

  task automatic t_narrow_ref();
    int b;
    mode = 2'b01; wide = 0; ref_ext = 1; irq_en = 0; ch_mask = 8'h81;
    b = log_n;
    do_start(3'd0);
    wait_idle();
    chk(log_n - b == 1, "R1 ch0 excluded count", log_n - b, 1);
    chk(log_ch[b] == 7, "R1 R2 channel", log_ch[b], 7);
    chk(log_hi[b] == 0, "R8 narrow hi", log_hi[b], 0);
    chk(log_lo[b] == (rval(7) >> 2), "R8 narrow lo", log_lo[b], rval(7) >> 2);
    chk(status[1] == 1'b1 && irq_n == 1'b1, "R10 irq disabled", int'(irq_n), 1);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic t_empty();
    int b, c;
    b = log_n; c = cs_cnt;
    mode = 2'b01; ref_ext = 0; ch_mask = 8'h00;
    do_start(3'd2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(status[0] == 1'b0, "R6 busy never set", int'(status[0]), 0);
    end
    ref_ext = 1; ch_mask = 8'h01;
    do_start(3'd0);
    repeat (20) @(negedge clk);
    chk(cs_cnt == c, "R6 R1 no launch", cs_cnt - c, 0);
    chk(log_n == b, "R6 no results", log_n - b, 0);
    ref_ext = 0;
  endtask

  task automatic t_step();
    int b;
    mode = 2'b00; wide = 1; ch_mask = 8'h0C;
    b = log_n;
    do_start(3'd3);
    repeat (40) @(negedge clk);
    chk(log_n - b == 1, "R5 one per start", log_n - b, 1);
    chk(log_ch[b] == 3, "R5 first channel", log_ch[b], 3);
    chk(status[0] == 1'b0, "R5 holds not busy", int'(status[0]), 0);
    do_step();
    repeat (40) @(negedge clk);
    chk(log_n - b == 2, "R5 one per step", log_n - b, 2);
    chk(log_ch[b+1] == 2, "R5 wrap to 2", log_ch[b+1], 2);
    do_step();
    repeat (40) @(negedge clk);
    chk(log_ch[b+2] == 3, "R5 back to 3", log_ch[b+2], 3);
    chk(log_n - b == 3, "R5 count", log_n - b, 3);
  endtask

  task automatic t_continuous();
    int b, n;
    mode = 2'b10; wide = 1; ch_mask = 8'h12;
    b = log_n;
    do_start(3'd4);
    for (int i = 0; i < 3000 && log_n - b < 5; i++) @(negedge clk);
    chk(status[0] == 1'b1, "R4 still running", int'(status[0]), 1);
    mode = 2'b01;
    wait_idle();
    n = log_n - b;
    chk(n >= 5 && n % 2 == 0, "R4 stops at pass end", n, 6);
    for (int k = 0; k < n; k++)
      chk(log_ch[b+k] == ((k % 2 == 0) ? 4 : 1), "R4 R2 repeat order",
          log_ch[b+k], (k % 2 == 0) ? 4 : 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_pass();
    t_narrow_ref();
    t_empty();
    t_step();
    t_continuous();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule